// File: doc/BRIEF.md
# Microprogrammed Multicycle Control Sequencer

This block is the control unit of a multicycle 32-bit load/store processor. A micro-program counter (micro-PC) steps through an internal microcode table. Each micro-address selects one control word for the datapath: the ALU operation and its operand sources, the register destination, the memory operation and address source, instruction-register load, PC load and the exception-register loads. The micro-PC itself is also driven out so the current control step can be seen.

The next micro-address comes from one of three sequencing modes: return to the fetch step, jump through an opcode-indexed dispatch table, or step to the next micro-address. A conditional micro-branch overrides the sequencing mode when the condition named by the current step is true. This is how arithmetic overflow and pending interrupts reach the exception microcode. An opcode with no dispatch entry goes to its own exception step. A memory step repeats for as long as the memory wait input is high. During that time the loads that change architectural state are held off.

The datapath, register file and memory sit outside this block. They consume the control outputs and return the opcode, the ALU zero and overflow flags, and the wait signal.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the micro-PC becomes 0. After reset is released, the fetch control word is on the outputs: `mem_read_o`=1, `mem_addr_sel_o`=0 (PC), `ir_write_o`=1, `pc_load_o`=1, `pc_src_o`=00 (ALU result), `alu_srca_o`=0 (PC), `alu_srcb_o`=00 (constant 4), `alu_op_o`=00 (add).
- R2: Micro-address 0 always advances to micro-address 1, even with an interrupt pending. Micro-address 1 drives `alu_op_o`=00, `alu_srca_o`=0 and `alu_srcb_o`=10 (sign-extended offset shifted left 2).
- R3: From micro-address 1, the dispatch table sends each opcode to its entry step: 000000 goes to 4, 000100 goes to 2, 001101 goes to 6, 100011 goes to 8 and 101011 goes to 11.
- R4: Each instruction steps through its own micro-address sequence and then returns to 0: load 8,9,10; store 11,12; register-register 4,5; OR-immediate 6,7; branch-if-equal 2.
- R5: Control encodings are as follows. `alu_op_o`: 00 add, 01 subtract, 10 function field, 11 OR. `alu_srcb_o`: 00 constant 4, 01 rt register, 10 extended offset shifted left 2, 11 extended immediate. `ext_sign_o`: 1 sign, 0 zero. `reg_dst_o`: 1 rd, 0 rt. `mem_to_reg_o`: 1 memory data, 0 ALU output. `mem_addr_sel_o`: 1 ALU output register, 0 PC. `mem_read_o` and `mem_write_o` are never high together.
- R6: When the opcode at micro-address 1 has no dispatch entry, the next micro-address is 16, with `cause_code_o`=10.
- R7: When `alu_ovf_i` is high at micro-address 4, the next micro-address is 17 (not 5), with `cause_code_o`=12.
- R8: When `irq_pending_i` is high at micro-address 1, the next micro-address is 18, with `cause_code_o`=0. This takes priority over dispatch, including dispatch of an undefined opcode.
- R9: Every exception step (16, 17, 18) drives `epc_write_o`=1, `cause_write_o`=1, `pc_load_o`=1, `pc_src_o`=10 (handler address), `alu_op_o`=01, `alu_srca_o`=0 and `alu_srcb_o`=00 (PC minus 4). The step after it is micro-address 0.
- R10: In a step with `mem_read_o` or `mem_write_o` high, a high `mem_wait_i` holds the micro-PC and forces `ir_write_o`, `pc_load_o`, `reg_write_o`, `epc_write_o` and `cause_write_o` to 0. The step advances in the first cycle where `mem_wait_i` is low.
- R11: `alu_ovf_i` has no effect outside micro-address 4, and `irq_pending_i` has no effect outside micro-address 1.
- R12: At micro-address 2, `pc_load_o` equals `alu_zero_i`, with `pc_src_o`=01 (ALU output register), `alu_op_o`=01 and `alu_srcb_o`=01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Instruction opcode from the instruction register |
| alu_zero_i | input | 1 | ALU result is zero |
| alu_ovf_i | input | 1 | ALU signed overflow |
| irq_pending_i | input | 1 | An enabled interrupt is pending |
| mem_wait_i | input | 1 | Memory not ready; repeat the current memory step |
| upc_o | output | 5 | Current micro-address |
| alu_op_o | output | 2 | ALU operation |
| alu_srca_o | output | 1 | ALU A source: 0 PC, 1 rs register |
| alu_srcb_o | output | 2 | ALU B source |
| ext_sign_o | output | 1 | Immediate extension: 1 sign, 0 zero |
| reg_write_o | output | 1 | Register file write enable |
| reg_dst_o | output | 1 | Destination register: 1 rd, 0 rt |
| mem_to_reg_o | output | 1 | Write-back data: 1 memory, 0 ALU output |
| mem_read_o | output | 1 | Memory read |
| mem_write_o | output | 1 | Memory write |
| mem_addr_sel_o | output | 1 | Memory address: 1 ALU output register, 0 PC |
| ir_write_o | output | 1 | Instruction register load |
| pc_load_o | output | 1 | PC load (conditional on zero in the branch step) |
| pc_src_o | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 handler address |
| epc_write_o | output | 1 | Exception PC load |
| cause_write_o | output | 1 | Cause register load |
| cause_code_o | output | 5 | Exception cause code |

## Verification
The assertions check the following on every cycle: micro-PC hold and write suppression during wait stalls, return to micro-address 0 after a fetch-mode step, the detours into the exception steps on overflow, pending interrupt and undefined opcode, the full exception control word, and the exclusion between memory read and write. The directed scenarios show the rest. They check the dispatch target for each opcode, the full micro-address path of each instruction class with its control encodings, and the zero-flag gating of the branch PC load. They also check that overflow and interrupt inputs applied at the wrong steps are ignored, and that a fetch or load stall lasts exactly as long as the wait input.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W    = 5;
  localparam int OPC_W   = 6;
  localparam int CAUSE_W = 5;

  typedef logic [UA_W-1:0] uaddr_t;

  typedef enum logic [1:0] {
    SEQ_FETCH    = 2'b00,
    SEQ_DISPATCH = 2'b01,
    SEQ_NEXT     = 2'b10
  } seq_e;

  typedef enum logic [1:0] {
    COND_NONE = 2'b00,
    COND_OVF  = 2'b01,
    COND_IRQ  = 2'b10
  } cond_e;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;
  localparam logic [1:0] ALU_OR   = 2'b11;

  localparam logic [1:0] SRCB_FOUR  = 2'b00;
  localparam logic [1:0] SRCB_RT    = 2'b01;
  localparam logic [1:0] SRCB_EXTSH = 2'b10;
  localparam logic [1:0] SRCB_EXT   = 2'b11;

  localparam logic [1:0] PCSRC_ALU     = 2'b00;
  localparam logic [1:0] PCSRC_ALUOUT  = 2'b01;
  localparam logic [1:0] PCSRC_HANDLER = 2'b10;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OPC_W-1:0] OP_SW    = 6'b101011;

  localparam uaddr_t UA_FETCH  = 5'd0;
  localparam uaddr_t UA_DECODE = 5'd1;
  localparam uaddr_t UA_BEQ    = 5'd2;
  localparam uaddr_t UA_RTYPE  = 5'd4;
  localparam uaddr_t UA_ORI    = 5'd6;
  localparam uaddr_t UA_LW     = 5'd8;
  localparam uaddr_t UA_SW     = 5'd11;
  localparam uaddr_t UA_UNDEF  = 5'd16;
  localparam uaddr_t UA_OVF    = 5'd17;
  localparam uaddr_t UA_INT    = 5'd18;

  localparam logic [CAUSE_W-1:0] CAUSE_INT   = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 5'd10;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 5'd12;

  typedef struct packed {
    logic [1:0]         alu_op;
    logic               srca;
    logic [1:0]         srcb;
    logic               ext_sign;
    logic               reg_write;
    logic               reg_dst;
    logic               mem_to_reg;
    logic               mem_read;
    logic               mem_write;
    logic               mem_addr_sel;
    logic               ir_write;
    logic               pc_write;
    logic               pc_write_cond;
    logic [1:0]         pc_src;
    logic               epc_write;
    logic               cause_write;
    logic [CAUSE_W-1:0] cause;
    cond_e              cond;
    seq_e               seq;
    uaddr_t             target;
  } ucw_t;

  // Exception step shared by all three causes: EPC <- PC - 4, PC <- handler.
  function automatic ucw_t exc_word(input logic [CAUSE_W-1:0] code);
    ucw_t w;
    w             = '0;
    w.alu_op      = ALU_SUB;
    w.srca        = 1'b0;
    w.srcb        = SRCB_FOUR;
    w.epc_write   = 1'b1;
    w.cause_write = 1'b1;
    w.cause       = code;
    w.pc_write    = 1'b1;
    w.pc_src      = PCSRC_HANDLER;
    w.seq         = SEQ_FETCH;
    return w;
  endfunction

  function automatic ucw_t ucode_word(input uaddr_t a);
    ucw_t w;
    w     = '0;
    w.seq = SEQ_FETCH;
    case (a)
      UA_FETCH: begin
        w.alu_op   = ALU_ADD;
        w.srcb     = SRCB_FOUR;
        w.mem_read = 1'b1;
        w.ir_write = 1'b1;
        w.pc_write = 1'b1;
        w.pc_src   = PCSRC_ALU;
        w.seq      = SEQ_NEXT;
      end
      UA_DECODE: begin
        w.alu_op   = ALU_ADD;
        w.srcb     = SRCB_EXTSH;
        w.ext_sign = 1'b1;
        w.cond     = COND_IRQ;
        w.target   = UA_INT;
        w.seq      = SEQ_DISPATCH;
      end
      UA_BEQ: begin
        w.alu_op        = ALU_SUB;
        w.srca          = 1'b1;
        w.srcb          = SRCB_RT;
        w.pc_write_cond = 1'b1;
        w.pc_src        = PCSRC_ALUOUT;
      end
      UA_RTYPE: begin
        w.alu_op = ALU_FUNC;
        w.srca   = 1'b1;
        w.srcb   = SRCB_RT;
        w.cond   = COND_OVF;
        w.target = UA_OVF;
        w.seq    = SEQ_NEXT;
      end
      5'd5: begin
        w.reg_write = 1'b1;
        w.reg_dst   = 1'b1;
      end
      UA_ORI: begin
        w.alu_op = ALU_OR;
        w.srca   = 1'b1;
        w.srcb   = SRCB_EXT;
        w.seq    = SEQ_NEXT;
      end
      5'd7: begin
        w.reg_write = 1'b1;
      end
      UA_LW, UA_SW: begin
        w.alu_op   = ALU_ADD;
        w.srca     = 1'b1;
        w.srcb     = SRCB_EXT;
        w.ext_sign = 1'b1;
        w.seq      = SEQ_NEXT;
      end
      5'd9: begin
        w.mem_read     = 1'b1;
        w.mem_addr_sel = 1'b1;
        w.seq          = SEQ_NEXT;
      end
      5'd10: begin
        w.reg_write  = 1'b1;
        w.mem_to_reg = 1'b1;
      end
      5'd12: begin
        w.mem_write    = 1'b1;
        w.mem_addr_sel = 1'b1;
      end
      UA_UNDEF: w = exc_word(CAUSE_UNDEF);
      UA_OVF:   w = exc_word(CAUSE_OVF);
      UA_INT:   w = exc_word(CAUSE_INT);
      default:  w.seq = SEQ_FETCH;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OPW = OPC_W
) (
  input  logic [OPW-1:0] opcode,
  output logic           hit,
  output uaddr_t         entry
);

  always_comb begin
    hit   = 1'b1;
    entry = UA_FETCH;
    case (opcode)
      OP_RTYPE: entry = UA_RTYPE;
      OP_BEQ:   entry = UA_BEQ;
      OP_ORI:   entry = UA_ORI;
      OP_LW:    entry = UA_LW;
      OP_SW:    entry = UA_SW;
      default:  hit   = 1'b0;
    endcase
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  uaddr_t upc,
  input  seq_e   seq,
  input  cond_e  cond,
  input  uaddr_t target,
  input  logic   ovf,
  input  logic   irq,
  input  logic   stall,
  input  logic   disp_hit,
  input  uaddr_t disp_entry,
  output logic   taken,
  output uaddr_t next
);

  always_comb begin
    taken = ((cond == COND_OVF) && ovf) || ((cond == COND_IRQ) && irq);
    if (stall) begin
      next = upc;
    end else if (taken) begin
      next = target;
    end else begin
      case (seq)
        SEQ_DISPATCH: next = disp_hit ? disp_entry : UA_UNDEF;
        SEQ_NEXT:     next = uaddr_t'(upc + 1'b1);
        default:      next = UA_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/useq_ucode_rom.sv
module useq_ucode_rom
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output ucw_t          word
);

  localparam int DEPTH = 1 << AW;

  ucw_t table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign table_w[i] = ucode_word(uaddr_t'(i));
  end

  // Synchronous read so the table can sit in a block RAM output register.
  always_ff @(posedge clk) begin
    if (rst) word <= table_w[0];
    else     word <= table_w[addr];
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OPW = OPC_W,
  parameter int UAW = UA_W,
  parameter int CW  = CAUSE_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode_i,
  input  logic           alu_zero_i,
  input  logic           alu_ovf_i,
  input  logic           irq_pending_i,
  input  logic           mem_wait_i,
  output logic [UAW-1:0] upc_o,
  output logic [1:0]     alu_op_o,
  output logic           alu_srca_o,
  output logic [1:0]     alu_srcb_o,
  output logic           ext_sign_o,
  output logic           reg_write_o,
  output logic           reg_dst_o,
  output logic           mem_to_reg_o,
  output logic           mem_read_o,
  output logic           mem_write_o,
  output logic           mem_addr_sel_o,
  output logic           ir_write_o,
  output logic           pc_load_o,
  output logic [1:0]     pc_src_o,
  output logic           epc_write_o,
  output logic           cause_write_o,
  output logic [CW-1:0]  cause_code_o
);

  uaddr_t upc_q;
  uaddr_t upc_d;
  ucw_t   cw_q;
  logic   stall;
  logic   taken;
  logic   disp_hit;
  uaddr_t disp_entry;

  useq_dispatch #(.OPW(OPW)) i_dispatch (
    .opcode (opcode_i),
    .hit    (disp_hit),
    .entry  (disp_entry)
  );

  assign stall = (cw_q.mem_read || cw_q.mem_write) && mem_wait_i;

  useq_next_addr i_next (
    .upc        (upc_q),
    .seq        (cw_q.seq),
    .cond       (cw_q.cond),
    .target     (cw_q.target),
    .ovf        (alu_ovf_i),
    .irq        (irq_pending_i),
    .stall      (stall),
    .disp_hit   (disp_hit),
    .disp_entry (disp_entry),
    .taken      (taken),
    .next       (upc_d)
  );

  useq_ucode_rom #(.AW(UAW)) i_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (upc_d),
    .word (cw_q)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= UA_FETCH;
    else     upc_q <= upc_d;
  end

  assign upc_o          = upc_q;
  assign alu_op_o       = cw_q.alu_op;
  assign alu_srca_o     = cw_q.srca;
  assign alu_srcb_o     = cw_q.srcb;
  assign ext_sign_o     = cw_q.ext_sign;
  assign reg_dst_o      = cw_q.reg_dst;
  assign mem_to_reg_o   = cw_q.mem_to_reg;
  assign mem_read_o     = cw_q.mem_read;
  assign mem_write_o    = cw_q.mem_write;
  assign mem_addr_sel_o = cw_q.mem_addr_sel;
  assign pc_src_o       = cw_q.pc_src;
  assign cause_code_o   = cw_q.cause;

  // State-changing loads are suppressed while a memory step is stalled.
  assign ir_write_o    = cw_q.ir_write    && !stall;
  assign reg_write_o   = cw_q.reg_write   && !stall;
  assign epc_write_o   = cw_q.epc_write   && !stall;
  assign cause_write_o = cw_q.cause_write && !stall;
  assign pc_load_o     = (cw_q.pc_write || (cw_q.pc_write_cond && alu_zero_i)) && !stall;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    stall |=> (upc_q == $past(upc_q)));

  assert_stall_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_wait_i && (mem_read_o || mem_write_o)) |-> (!ir_write_o && !pc_load_o && !reg_write_o));

  assert_fetch_return_R4: assert property (@(posedge clk) disable iff (rst)
    (!stall && !taken && cw_q.seq == SEQ_FETCH) |=> (upc_q == UA_FETCH));

  assert_undef_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UA_DECODE && !irq_pending_i && !disp_hit) |=> (upc_q == UA_UNDEF));

  assert_ovf_branch_R7: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UA_RTYPE && alu_ovf_i) |=> (upc_q == UA_OVF));

  assert_irq_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UA_DECODE && irq_pending_i) |=> (upc_q == UA_INT));

  assert_exc_word_R9: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UA_UNDEF || upc_q == UA_OVF || upc_q == UA_INT)
      |-> (epc_write_o && cause_write_o && pc_load_o && pc_src_o == PCSRC_HANDLER));

  assert_mem_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_read_o && mem_write_o));

endmodule

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       zero = 1'b0, ovf = 1'b0, irq = 1'b0, mwait = 1'b0;
  logic [4:0] upc;
  logic [1:0] alu_op, srcb, pc_src;
  logic       srca, ext_sign, reg_write, reg_dst, mem_to_reg;
  logic       mem_read, mem_write, mem_addr_sel, ir_write, pc_load;
  logic       epc_write, cause_write;
  logic [4:0] cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  useq_ctrl i_useq_ctrl (
    .clk(clk), .rst(rst), .opcode_i(opcode), .alu_zero_i(zero), .alu_ovf_i(ovf),
    .irq_pending_i(irq), .mem_wait_i(mwait), .upc_o(upc), .alu_op_o(alu_op),
    .alu_srca_o(srca), .alu_srcb_o(srcb), .ext_sign_o(ext_sign),
    .reg_write_o(reg_write), .reg_dst_o(reg_dst), .mem_to_reg_o(mem_to_reg),
    .mem_read_o(mem_read), .mem_write_o(mem_write), .mem_addr_sel_o(mem_addr_sel),
    .ir_write_o(ir_write), .pc_load_o(pc_load), .pc_src_o(pc_src),
    .epc_write_o(epc_write), .cause_write_o(cause_write), .cause_code_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one clock; inputs settle at the falling edge.
  task automatic adv();
    @(negedge clk);
    #1;
  endtask

  task automatic fetch_decode(input logic [5:0] op);
    opcode = op;
    #1;
    chk("R2 fetch upc", upc, 0);
    adv();
    chk("R2 decode upc", upc, 1);
    chk("R2 decode srcb", srcb, 2);
    chk("R2 decode alu_op", alu_op, 0);
    adv();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 upc", upc, 0);
    chk("R1 mem_read", mem_read, 1);
    chk("R1 ir_write", ir_write, 1);
    chk("R1 pc_load", pc_load, 1);
    chk("R1 srcb", srcb, 0);
    chk("R1 pc_src", pc_src, 0);
    chk("R1 mem_addr_sel", mem_addr_sel, 0);
  endtask

  task automatic t_rtype();
    fetch_decode(6'b000000);
    chk("R3 rtype entry", upc, 4);
    chk("R5 rtype alu_op func", alu_op, 2);
    chk("R5 rtype srcb rt", srcb, 1);
    adv();
    chk("R4 rtype wb upc", upc, 5);
    chk("R5 rtype reg_write", reg_write, 1);
    chk("R5 rtype reg_dst rd", reg_dst, 1);
    chk("R5 rtype mem_to_reg", mem_to_reg, 0);
    adv();
    chk("R4 rtype return", upc, 0);
  endtask

  task automatic t_ori_ignore_ovf();
    fetch_decode(6'b001101);
    chk("R3 ori entry", upc, 6);
    chk("R5 ori alu_op or", alu_op, 3);
    chk("R5 ori srcb ext", srcb, 3);
    chk("R5 ori zero ext", ext_sign, 0);
    ovf = 1'b1;
    adv();
    ovf = 1'b0;
    chk("R11 ovf ignored at ori", upc, 7);
    chk("R5 ori reg_dst rt", reg_dst, 0);
    adv();
    chk("R4 ori return", upc, 0);
  endtask

  task automatic t_lw_wait();
    fetch_decode(6'b100011);
    chk("R3 lw entry", upc, 8);
    chk("R5 lw sign ext", ext_sign, 1);
    adv();
    chk("R4 lw mem upc", upc, 9);
    chk("R5 lw addr sel", mem_addr_sel, 1);
    mwait = 1'b1;
    for (int k = 0; k < 3; k++) begin
      adv();
      chk("R10 lw stall hold", upc, 9);
    end
    mwait = 1'b0;
    adv();
    chk("R4 lw wb upc", upc, 10);
    chk("R5 lw mem_to_reg", mem_to_reg, 1);
    chk("R5 lw reg_write", reg_write, 1);
    adv();
    chk("R4 lw return", upc, 0);
  endtask

  task automatic t_fetch_wait();
    mwait = 1'b1;
    #1;
    chk("R10 fetch ir_write gated", ir_write, 0);
    chk("R10 fetch pc_load gated", pc_load, 0);
    adv();
    chk("R10 fetch hold", upc, 0);
    mwait = 1'b0;
    #1;
    chk("R10 fetch ir_write released", ir_write, 1);
    adv();
    chk("R10 fetch advance", upc, 1);
    opcode = 6'b101011;
    adv();
    chk("R3 sw entry", upc, 11);
    adv();
    chk("R4 sw mem upc", upc, 12);
    chk("R5 sw mem_write", mem_write, 1);
    chk("R5 sw no read", mem_read, 0);
    adv();
    chk("R4 sw return", upc, 0);
  endtask

  task automatic t_beq(input logic z);
    fetch_decode(6'b000100);
    chk("R3 beq entry", upc, 2);
    zero = z;
    #1;
    chk("R12 beq pc_load", pc_load, int'(z));
    chk("R12 beq pc_src", pc_src, 1);
    chk("R12 beq alu_op", alu_op, 1);
    chk("R12 beq srcb", srcb, 1);
    adv();
    zero = 1'b0;
    chk("R4 beq return", upc, 0);
  endtask

  task automatic exc_check(input string req, input int ua, input int code);
    chk({req, " upc"}, upc, ua);
    chk({req, " cause"}, cause, code);
    chk("R9 epc_write", epc_write, 1);
    chk("R9 cause_write", cause_write, 1);
    chk("R9 pc_load", pc_load, 1);
    chk("R9 pc_src", pc_src, 2);
    chk("R9 alu_op sub", alu_op, 1);
    chk("R9 srcb four", srcb, 0);
    chk("R9 srca pc", srca, 0);
    adv();
    chk("R9 return", upc, 0);
  endtask

  task automatic t_undef();
    fetch_decode(6'b000010);
    exc_check("R6", 16, 10);
  endtask

  task automatic t_ovf();
    fetch_decode(6'b000000);
    ovf = 1'b1;
    adv();
    ovf = 1'b0;
    exc_check("R7", 17, 12);
  endtask

  task automatic t_irq();
    irq = 1'b1;
    opcode = 6'b000010;
    #1;
    adv();
    chk("R11 irq ignored at fetch", upc, 1);
    adv();
    irq = 1'b0;
    exc_check("R8", 18, 0);
  endtask

  initial begin
    t_reset();
    t_rtype();
    t_ori_ignore_ovf();
    t_lw_wait();
    t_fetch_wait();
    t_beq(1'b1);
    t_beq(1'b0);
    t_undef();
    t_ovf();
    t_irq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule